// File: doc/BRIEF.md
# Unaligned Word Merge Unit

This block forms the data for the left and right partial-word load and store instructions of a little-endian 32-bit core. A single unaligned word is reached with two such instructions, one touching each of the two aligned words it straddles. Each instruction reads only the aligned word. It then merges a variable number of bytes from one source into the old contents of the other.

The unit is purely combinational. A one-hot select names the operation, and the two low bits of the effective address give the byte offset. The aligned memory word and the destination register value are also inputs. For a load, the register input is the value the pipeline has already chosen, including any pending delayed-load value for the same register. The result is either the new register value or the word to write back to the aligned address. No alignment fault is raised for any offset. Address generation, the memory access itself and bypass selection sit outside the block.

Top module: `unaligned_merge`

## Requirements
- R1: With `op_sel` = 4'b0001 (load-left) and byte offset k, bytes 3-k..3 of `result` are memory bytes 0..k in order, and the lower bytes keep `reg_word`.
- R2: With `op_sel` = 4'b0010 (load-right), bytes 0..3-k of `result` are memory bytes k..3 in order, and the upper bytes keep `reg_word`.
- R3: With `op_sel` = 4'b0100 (store-left), bytes 0..k of `result` are register bytes 3-k..3 in order, and the upper bytes keep `mem_word`.
- R4: With `op_sel` = 4'b1000 (store-right), bytes k..3 of `result` are register bytes 0..3-k in order, and the lower bytes keep `mem_word`.
- R5: At offset 0, load-right returns `mem_word` whole, and store-left replaces only byte 0 with register byte 3.
- R6: At offset 3, load-left returns `mem_word` whole. Store-right returns `reg_word` whole at offset 0, and at offset 3 it replaces only byte 3 with register byte 0.
- R7: When `op_sel` is not exactly one-hot, `result` is zero.
- R8: A load-right at address a followed by a load-left at a+3, with the first result fed back as the register value, yields the four bytes starting at a. A store-right at a and a store-left at a+3 place the register bytes at a..a+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | One-hot operation: bit0 load-left, bit1 load-right, bit2 store-left, bit3 store-right |
| addr_lo | input | 2 | Low bits of the effective address (byte offset k) |
| mem_word | input | 32 | Aligned memory word |
| reg_word | input | 32 | Current (possibly bypassed) register value |
| result | output | 32 | Merged register value or merged store word |

## Verification
The two operations that meet in one result are the right-half access and the left-half access of a straddling word. For loads they meet in the register, and for stores in the pair of memory words. The bench runs a load-right, then feeds its result back as the register input of a load-left at address+3 in the following cycle. It judges the final value against the word it slices out of two memory words at each offset 1 to 3. The store pair is judged the same way against the two words with four register bytes written in at the offset.

// File: rtl/umrg_pkg.sv
package umrg_pkg;
  typedef enum logic [3:0] {
    OP_LD_LEFT  = 4'b0001,
    OP_LD_RIGHT = 4'b0010,
    OP_ST_LEFT  = 4'b0100,
    OP_ST_RIGHT = 4'b1000
  } umrg_op_e;

  localparam int unsigned OP_W = 4;
endpackage

// File: rtl/umrg_lane_ctl.sv
module umrg_lane_ctl
  import umrg_pkg::*;
#(
  parameter int unsigned BYTES = 4,
  localparam int unsigned IDXW = $clog2(BYTES)
) (
  input  logic [OP_W-1:0]  sel,
  input  logic [IDXW-1:0]  ofs,
  output logic [BYTES-1:0] take_new,
  output logic [IDXW-1:0]  rot,
  output logic             src_is_mem,
  output logic             sel_ok
);
  localparam int LAST = BYTES - 1;

  logic is_ll, is_lr, is_sl, is_sr;

  always_comb begin
    is_ll  = (sel == OP_LD_LEFT);
    is_lr  = (sel == OP_LD_RIGHT);
    is_sl  = (sel == OP_ST_LEFT);
    is_sr  = (sel == OP_ST_RIGHT);
    sel_ok = is_ll | is_lr | is_sl | is_sr;
    src_is_mem = is_ll | is_lr;
    // rotation so that lane j of the rotated source holds its byte
    unique case (1'b1)
      is_ll:   rot = ofs + IDXW'(1);
      is_lr:   rot = ofs;
      is_sl:   rot = IDXW'(LAST) - ofs;
      is_sr:   rot = IDXW'(0) - ofs;
      default: rot = '0;
    endcase
  end

  for (genvar j = 0; j < BYTES; j++) begin : g_lane
    always_comb begin
      take_new[j] = (is_ll && (j >= LAST - int'(ofs))) ||
                    (is_lr && (j <= LAST - int'(ofs))) ||
                    (is_sl && (j <= int'(ofs)))        ||
                    (is_sr && (j >= int'(ofs)));
    end
  end
endmodule

// File: rtl/umrg_byte_rot.sv
module umrg_byte_rot #(
  parameter int unsigned BYTES = 4,
  localparam int unsigned IDXW = $clog2(BYTES),
  localparam int unsigned WIDTH = 8 * BYTES
) (
  input  logic [WIDTH-1:0] din,
  input  logic [IDXW-1:0]  rot,
  output logic [WIDTH-1:0] dout
);
  for (genvar j = 0; j < BYTES; j++) begin : g_byte
    logic [IDXW-1:0] src_idx;
    always_comb begin
      src_idx = IDXW'(j) + rot;
      dout[8*j +: 8] = din[8*src_idx +: 8];
    end
  end
endmodule

// File: rtl/umrg_lane_mux.sv
module umrg_lane_mux #(
  parameter int unsigned BYTES = 4,
  localparam int unsigned WIDTH = 8 * BYTES
) (
  input  logic [WIDTH-1:0] new_word,
  input  logic [WIDTH-1:0] old_word,
  input  logic [BYTES-1:0] take_new,
  input  logic             sel_ok,
  output logic [WIDTH-1:0] merged
);
  for (genvar j = 0; j < BYTES; j++) begin : g_mux
    always_comb begin
      if (!sel_ok)          merged[8*j +: 8] = 8'h00;
      else if (take_new[j]) merged[8*j +: 8] = new_word[8*j +: 8];
      else                  merged[8*j +: 8] = old_word[8*j +: 8];
    end
  end
endmodule

// File: rtl/unaligned_merge.sv
module unaligned_merge
  import umrg_pkg::*;
#(
  parameter int unsigned BYTES = 4,
  localparam int unsigned IDXW = $clog2(BYTES),
  localparam int unsigned WIDTH = 8 * BYTES
) (
  input  logic [OP_W-1:0]  op_sel,
  input  logic [IDXW-1:0]  addr_lo,
  input  logic [WIDTH-1:0] mem_word,
  input  logic [WIDTH-1:0] reg_word,
  output logic [WIDTH-1:0] result
);
  logic [BYTES-1:0] take_new;
  logic [IDXW-1:0]  rot;
  logic             src_is_mem;
  logic             sel_ok;
  logic [WIDTH-1:0] src_word;
  logic [WIDTH-1:0] old_word;
  logic [WIDTH-1:0] rot_word;

  umrg_lane_ctl #(.BYTES(BYTES)) u_ctl (
    .sel        (op_sel),
    .ofs        (addr_lo),
    .take_new   (take_new),
    .rot        (rot),
    .src_is_mem (src_is_mem),
    .sel_ok     (sel_ok)
  );

  always_comb begin
    src_word = src_is_mem ? mem_word : reg_word;
    old_word = src_is_mem ? reg_word : mem_word;
  end

  umrg_byte_rot #(.BYTES(BYTES)) u_rot (
    .din  (src_word),
    .rot  (rot),
    .dout (rot_word)
  );

  umrg_lane_mux #(.BYTES(BYTES)) u_mux (
    .new_word (rot_word),
    .old_word (old_word),
    .take_new (take_new),
    .sel_ok   (sel_ok),
    .merged   (result)
  );
endmodule

// File: rtl/unaligned_merge_chk.sv
module unaligned_merge_chk #(
  parameter int unsigned BYTES = 4,
  localparam int unsigned IDXW = $clog2(BYTES),
  localparam int unsigned WIDTH = 8 * BYTES
) (
  input logic [3:0]       op_sel,
  input logic [IDXW-1:0]  addr_lo,
  input logic [WIDTH-1:0] mem_word,
  input logic [WIDTH-1:0] reg_word,
  input logic [WIDTH-1:0] result
);
  localparam int LAST = BYTES - 1;

  always_comb begin
    if (op_sel == 4'b0001 && int'(addr_lo) < LAST)
      AST_LL_LOW_KEPT: assert (result[7:0] == reg_word[7:0]); // R1
    if (op_sel == 4'b0010)
      AST_LR_LOW_BYTE: assert (result[7:0] == mem_word[8*addr_lo +: 8]); // R2
    if (op_sel == 4'b0100 && int'(addr_lo) < LAST)
      AST_SL_TOP_KEPT: assert (result[WIDTH-1 -: 8] == mem_word[WIDTH-1 -: 8]); // R3
    if (op_sel == 4'b1000)
      AST_SR_TOP_BYTE: assert (result[WIDTH-1 -: 8] == reg_word[8*(IDXW'(LAST) - addr_lo) +: 8]); // R4
    if (op_sel == 4'b0010 && addr_lo == '0)
      AST_LR_WHOLE: assert (result == mem_word); // R5
    if (op_sel == 4'b0001 && int'(addr_lo) == LAST)
      AST_LL_WHOLE: assert (result == mem_word); // R6
    if (op_sel == 4'b1000 && addr_lo == '0)
      AST_SR_WHOLE: assert (result == reg_word); // R6
    if (!$onehot(op_sel))
      AST_BAD_SEL_ZERO: assert (result == '0); // R7
  end
endmodule

bind unaligned_merge unaligned_merge_chk #(.BYTES(BYTES)) u_chk (
  .op_sel   (op_sel),
  .addr_lo  (addr_lo),
  .mem_word (mem_word),
  .reg_word (reg_word),
  .result   (result)
);

// File: tb/unaligned_merge_test.sv
module unaligned_merge_test;
  logic        clk;
  logic        rst_n;
  logic [3:0]  op_sel;
  logic [1:0]  addr_lo;
  logic [31:0] mem_word;
  logic [31:0] reg_word;
  logic [31:0] result;

  int checks;
  int fails;
  bit done;

  unaligned_merge uut (
    .op_sel   (op_sel),
    .addr_lo  (addr_lo),
    .mem_word (mem_word),
    .reg_word (reg_word),
    .result   (result)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {op, addr, mem, reg, expected}
  localparam int NV = 19;
  localparam logic [101:0] VEC [NV] = '{
    {4'b0001, 2'd0, 32'hA3A2A1A0, 32'hB3B2B1B0, 32'hA0B2B1B0},
    {4'b0001, 2'd1, 32'hA3A2A1A0, 32'hB3B2B1B0, 32'hA1A0B1B0},
    {4'b0001, 2'd2, 32'hA3A2A1A0, 32'hB3B2B1B0, 32'hA2A1A0B0},
    {4'b0001, 2'd3, 32'hA3A2A1A0, 32'hB3B2B1B0, 32'hA3A2A1A0},
    {4'b0010, 2'd0, 32'hA3A2A1A0, 32'hB3B2B1B0, 32'hA3A2A1A0},
    {4'b0010, 2'd1, 32'hA3A2A1A0, 32'hB3B2B1B0, 32'hB3A3A2A1},
    {4'b0010, 2'd2, 32'hA3A2A1A0, 32'hB3B2B1B0, 32'hB3B2A3A2},
    {4'b0010, 2'd3, 32'hA3A2A1A0, 32'hB3B2B1B0, 32'hB3B2B1A3},
    {4'b0100, 2'd0, 32'hA3A2A1A0, 32'hB3B2B1B0, 32'hA3A2A1B3},
    {4'b0100, 2'd1, 32'hA3A2A1A0, 32'hB3B2B1B0, 32'hA3A2B3B2},
    {4'b0100, 2'd2, 32'hA3A2A1A0, 32'hB3B2B1B0, 32'hA3B3B2B1},
    {4'b0100, 2'd3, 32'hA3A2A1A0, 32'hB3B2B1B0, 32'hB3B2B1B0},
    {4'b1000, 2'd0, 32'hA3A2A1A0, 32'hB3B2B1B0, 32'hB3B2B1B0},
    {4'b1000, 2'd1, 32'hA3A2A1A0, 32'hB3B2B1B0, 32'hB2B1B0A0},
    {4'b1000, 2'd2, 32'hA3A2A1A0, 32'hB3B2B1B0, 32'hB1B0A1A0},
    {4'b1000, 2'd3, 32'hA3A2A1A0, 32'hB3B2B1B0, 32'hB0A2A1A0},
    {4'b0000, 2'd1, 32'hA3A2A1A0, 32'hB3B2B1B0, 32'h00000000},
    {4'b0011, 2'd2, 32'hA3A2A1A0, 32'hB3B2B1B0, 32'h00000000},
    {4'b1111, 2'd3, 32'hA3A2A1A0, 32'hB3B2B1B0, 32'h00000000}
  };

  task automatic apply(input logic [3:0] op, input logic [1:0] a,
                       input logic [31:0] m, input logic [31:0] r);
    @(negedge clk);
    op_sel = op; addr_lo = a; mem_word = m; reg_word = r;
    #3;
  endtask

  task automatic check(input string req, input logic [31:0] exp);
    checks++;
    if (result !== exp) begin
      fails++;
      $display("FAIL %s: result=%08h expected=%08h", req, result, exp);
    end
  endtask

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'b0001: return "R1";
      4'b0010: return "R2";
      4'b0100: return "R3";
      4'b1000: return "R4";
      default: return "R7";
    endcase
  endfunction

  initial begin
    int cyc;
    for (cyc = 0; cyc < 100000 && !done; cyc++) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: expired after %0d cycles, expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] w0, w1, tmp, rv;
    logic [63:0] pair, msk;
    checks = 0; fails = 0; done = 0;
    rst_n = 1'b0;
    op_sel = 4'b0000; addr_lo = 2'd0; mem_word = 32'h12345678; reg_word = 32'h9ABCDEF0;
    repeat (3) @(posedge clk);
    #3;
    check("R7 reset-idle select", 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][101:98], VEC[i][97:96], VEC[i][95:64], VEC[i][63:32]);
      check(tag_of(VEC[i][101:98]), VEC[i][31:0]);
    end

    // corners with another data pattern
    apply(4'b0010, 2'd0, 32'h0F1E2D3C, 32'hFFFFFFFF);
    check("R5 load-right offset0 whole", 32'h0F1E2D3C);
    apply(4'b0100, 2'd0, 32'h0F1E2D3C, 32'h55667788);
    check("R5 store-left offset0 byte0", 32'h0F1E2D55);
    apply(4'b0001, 2'd3, 32'h0F1E2D3C, 32'h00000000);
    check("R6 load-left offset3 whole", 32'h0F1E2D3C);
    apply(4'b1000, 2'd0, 32'h0F1E2D3C, 32'h55667788);
    check("R6 store-right offset0 whole", 32'h55667788);
    apply(4'b1000, 2'd3, 32'h0F1E2D3C, 32'h55667788);
    check("R6 store-right offset3 top byte", 32'h881E2D3C);
    apply(4'b0110, 2'd0, 32'h0F1E2D3C, 32'h55667788);
    check("R7 two bits set", 32'h0);

    // paired accesses at offsets 1..3
    w0 = 32'h13579BDF; w1 = 32'h2468ACE0;
    for (int k = 1; k < 4; k++) begin
      pair = {w1, w0};
      apply(4'b0010, 2'(k), w0, 32'hDEADBEEF);
      tmp = result;
      apply(4'b0001, 2'(k - 1), w1, tmp);
      rv = pair[8*k +: 32];
      check("R8 load pair", rv);

      rv = 32'hC0FFEE11;
      msk = 64'hFFFFFFFF << (8 * k);
      pair = ({w1, w0} & ~msk) | ({32'h0, rv} << (8 * k));
      apply(4'b1000, 2'(k), w0, rv);
      check("R8 store pair low word", pair[31:0]);
      apply(4'b0100, 2'(k - 1), w1, rv);
      check("R8 store pair high word", pair[63:32]);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule